// File: doc/BRIEF.md
# CPU Address-Space Router

This block sits between an 8-bit CPU bus with a 16-bit address and the memories and register files of a small system. For each access it decodes the address into one of eleven regions. It forms the local address of the selected target and returns that target's read byte without delay. It raises a write strobe toward the target only when the write is allowed.

The four large targets are reached through external ports: cartridge ROM, video RAM, cartridge RAM and work RAM. The I/O register file is also external. The sprite attribute table, high RAM and the interrupt-enable byte are held inside the block.

The block takes three inputs from outside the bus:
- the switchable ROM bank number, supplied by a separate bank controller;
- the cartridge-RAM enable, also from the bank controller;
- the current video mode, which gates the sprite table.

Writes that land in the ROM window do not touch ROM. They are handed to the bank controller instead.

Top module: `mem_router`

## Requirements
- R1: Addresses 0x0000–0x3FFF read ROM through `rom_addr` = the low 14 address bits with the bank field forced to zero; `cpu_rdata` equals `rom_rdata`.
- R2: Addresses 0x4000–0x7FFF read ROM at `rom_addr` = {`rom_bank_sel`, address[13:0]}.
- R3: A write anywhere in 0x0000–0x7FFF raises `mbc_we` and no other write strobe; ROM is never written.
- R4: 0x8000–0x9FFF reach video RAM at `vram_addr` = address − 0x8000, for both reads and writes (`vram_we`).
- R5: 0xA000–0xBFFF reach cartridge RAM at `xram_addr` = address − 0xA000 only while `xram_en` is 1; while it is 0, reads return 0xFF and `xram_we` stays low.
- R6: 0xC000–0xCFFF and 0xE000–0xEFFF both reach work-RAM bank 0 (`wram_addr` = {0, address[11:0]}); 0xD000–0xDFFF reaches bank 1 (`wram_addr` = {1, address[11:0]}).
- R7: 0xF000–0xFDFF mirrors work-RAM bank 1: `wram_addr` = {1, address[11:0]}.
- R8: The 160-byte sprite table at 0xFE00–0xFE9F is read and written only while `vid_mode` is 0 or 1. In modes 2 and 3, reads return 0xFF and writes leave the stored byte unchanged.
- R9: 0xFEA0–0xFEFF reads 0xFF; writes there raise no strobe and alter no stored byte.
- R10: 0xFF00–0xFF7F reaches the I/O file at `io_addr` = address[6:0], with `io_we` on writes.
- R11: 0xFF80–0xFFFE is a 127-byte internal high RAM that returns the last byte written to each address.
- R12: 0xFFFF is the interrupt-enable byte: it reads 0x00 after reset and returns the last byte written.
- R13: Read data follows the address in the same cycle; a write takes effect at the rising clock edge, so a read of the address being written in that cycle still returns the old byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_we | input | 1 | CPU write strobe |
| cpu_wdata | input | 8 | CPU write byte (also fed directly to external targets) |
| cpu_rdata | output | 8 | Read byte from the selected target, combinational |
| rom_bank_sel | input | ROM_BANK_W | Switchable ROM bank from the bank controller |
| xram_en | input | 1 | Cartridge-RAM enable from the bank controller |
| vid_mode | input | 2 | Current video mode |
| mbc_we | output | 1 | Write to the bank controller (ROM-window write) |
| rom_addr | output | ROM_BANK_W+14 | ROM byte address |
| rom_rdata | input | 8 | ROM read byte |
| vram_addr | output | 13 | Video-RAM byte address |
| vram_we | output | 1 | Video-RAM write strobe |
| vram_rdata | input | 8 | Video-RAM read byte |
| xram_addr | output | 13 | Cartridge-RAM byte address |
| xram_we | output | 1 | Cartridge-RAM write strobe |
| xram_rdata | input | 8 | Cartridge-RAM read byte |
| wram_addr | output | 13 | Work-RAM address: bank bit, then 12-bit offset |
| wram_we | output | 1 | Work-RAM write strobe |
| wram_rdata | input | 8 | Work-RAM read byte |
| io_addr | output | 7 | I/O register index |
| io_we | output | 1 | I/O write strobe |
| io_rdata | input | 8 | I/O read byte |

## Verification
Routing results are due in the same cycle as the stimulus. `cpu_rdata`, every external address and every write strobe are pure functions of the present inputs. The bench therefore drives a new access on the falling edge and compares these outputs with its model 1 ns later, well before the next rising edge.

The internal stores (sprite table, high RAM, interrupt enable) are different. They change at the rising edge that ends a write cycle. The model commits a write only after that edge, so the byte written becomes visible to the access issued one cycle later. A read in the writing cycle is checked against the old byte.

// File: rtl/mem_router_pkg.sv
package mem_router_pkg;

  typedef enum logic [3:0] {
    RG_ROM0, RG_ROMX, RG_VRAM, RG_XRAM, RG_WRAM0, RG_WRAM1,
    RG_OAM, RG_DEAD, RG_IO, RG_HRAM, RG_IE
  } region_e;

  localparam logic [15:0] OAM_BASE  = 16'hFE00;
  localparam logic [15:0] DEAD_BASE = 16'hFEA0;
  localparam logic [15:0] IO_BASE   = 16'hFF00;
  localparam logic [15:0] HRAM_BASE = 16'hFF80;
  localparam logic [15:0] IE_ADDR   = 16'hFFFF;

  localparam int OAM_BYTES  = 160;
  localparam int HRAM_BYTES = 127;
  localparam int ROM_OFS_W  = 14;
  localparam int WRAM_OFS_W = 12;
  localparam int WIN8K_W    = 13;
  localparam int IO_W       = 7;

  localparam logic [7:0] OPEN_BUS = 8'hFF;

endpackage

// File: rtl/mem_router_decode.sv
module mem_router_decode
  import mem_router_pkg::*;
(
  input  logic [15:0] addr,
  output region_e     region
);

  always_comb begin
    case (addr[15:12])
      4'h0, 4'h1, 4'h2, 4'h3: region = RG_ROM0;
      4'h4, 4'h5, 4'h6, 4'h7: region = RG_ROMX;
      4'h8, 4'h9:             region = RG_VRAM;
      4'hA, 4'hB:             region = RG_XRAM;
      4'hC, 4'hE:             region = RG_WRAM0;
      4'hD:                   region = RG_WRAM1;
      default: begin
        if (addr < OAM_BASE)       region = RG_WRAM1;
        else if (addr < DEAD_BASE) region = RG_OAM;
        else if (addr < IO_BASE)   region = RG_DEAD;
        else if (addr < HRAM_BASE) region = RG_IO;
        else if (addr < IE_ADDR)   region = RG_HRAM;
        else                       region = RG_IE;
      end
    endcase
  end

endmodule

// File: rtl/mem_router_bytes.sv
module mem_router_bytes #(
  parameter int DEPTH = 128,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);

  logic [7:0] mem [DEPTH];
  logic       in_range;

  assign in_range = (32'(addr) < DEPTH);

  always_ff @(posedge clk) begin
    if (we && in_range) mem[addr] <= wdata;
  end

  always_comb begin
    rdata = 8'hFF;
    if (in_range) rdata = mem[addr];
  end

endmodule

// File: rtl/mem_router.sv
module mem_router
  import mem_router_pkg::*;
#(
  parameter int ROM_BANK_W = 7,
  localparam int ROM_AW    = ROM_BANK_W + ROM_OFS_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [15:0]           cpu_addr,
  input  logic                  cpu_we,
  input  logic [7:0]            cpu_wdata,
  output logic [7:0]            cpu_rdata,
  input  logic [ROM_BANK_W-1:0] rom_bank_sel,
  input  logic                  xram_en,
  input  logic [1:0]            vid_mode,
  output logic                  mbc_we,
  output logic [ROM_AW-1:0]     rom_addr,
  input  logic [7:0]            rom_rdata,
  output logic [WIN8K_W-1:0]    vram_addr,
  output logic                  vram_we,
  input  logic [7:0]            vram_rdata,
  output logic [WIN8K_W-1:0]    xram_addr,
  output logic                  xram_we,
  input  logic [7:0]            xram_rdata,
  output logic [WIN8K_W-1:0]    wram_addr,
  output logic                  wram_we,
  input  logic [7:0]            wram_rdata,
  output logic [IO_W-1:0]       io_addr,
  output logic                  io_we,
  input  logic [7:0]            io_rdata
);

  localparam int OAM_AW  = $clog2(OAM_BYTES);
  localparam int HRAM_AW = $clog2(HRAM_BYTES);

  // reset: asserted at once, released through two flops
  logic rst_s1, rst_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_ok <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_ok <= rst_s1;
    end
  end

  region_e region;

  mem_router_decode u_decode (
    .addr   (cpu_addr),
    .region (region)
  );

  logic oam_open;
  assign oam_open = ~vid_mode[1];

  // external addresses always driven, strobes gated by region
  assign rom_addr  = (region == RG_ROMX) ? {rom_bank_sel, cpu_addr[ROM_OFS_W-1:0]}
                                         : {{ROM_BANK_W{1'b0}}, cpu_addr[ROM_OFS_W-1:0]};
  assign vram_addr = cpu_addr[WIN8K_W-1:0];
  assign xram_addr = cpu_addr[WIN8K_W-1:0];
  assign wram_addr = {(region == RG_WRAM1), cpu_addr[WRAM_OFS_W-1:0]};
  assign io_addr   = cpu_addr[IO_W-1:0];

  assign mbc_we  = cpu_we && (region == RG_ROM0 || region == RG_ROMX);
  assign vram_we = cpu_we && (region == RG_VRAM);
  assign xram_we = cpu_we && (region == RG_XRAM) && xram_en;
  assign wram_we = cpu_we && (region == RG_WRAM0 || region == RG_WRAM1);
  assign io_we   = cpu_we && (region == RG_IO);

  logic oam_we, hram_we, ie_we;
  assign oam_we  = cpu_we && (region == RG_OAM) && oam_open;
  assign hram_we = cpu_we && (region == RG_HRAM);
  assign ie_we   = cpu_we && (region == RG_IE);

  logic [7:0] oam_rd, hram_rd;

  mem_router_bytes #(.DEPTH(OAM_BYTES), .AW(OAM_AW)) u_oam (
    .clk   (clk),
    .we    (oam_we),
    .addr  (cpu_addr[OAM_AW-1:0]),
    .wdata (cpu_wdata),
    .rdata (oam_rd)
  );

  mem_router_bytes #(.DEPTH(HRAM_BYTES), .AW(HRAM_AW)) u_hram (
    .clk   (clk),
    .we    (hram_we),
    .addr  (cpu_addr[HRAM_AW-1:0]),
    .wdata (cpu_wdata),
    .rdata (hram_rd)
  );

  // interrupt-enable byte: next-state and register split
  logic [7:0] ie_q, ie_d;
  always_comb begin
    ie_d = ie_q;
    if (ie_we) ie_d = cpu_wdata;
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) ie_q <= 8'h00;
    else         ie_q <= ie_d;
  end

  always_comb begin
    case (region)
      RG_ROM0, RG_ROMX:  cpu_rdata = rom_rdata;
      RG_VRAM:           cpu_rdata = vram_rdata;
      RG_XRAM:           cpu_rdata = xram_en ? xram_rdata : OPEN_BUS;
      RG_WRAM0, RG_WRAM1: cpu_rdata = wram_rdata;
      RG_OAM:            cpu_rdata = oam_open ? oam_rd : OPEN_BUS;
      RG_IO:             cpu_rdata = io_rdata;
      RG_HRAM:           cpu_rdata = hram_rd;
      RG_IE:             cpu_rdata = ie_q;
      default:           cpu_rdata = OPEN_BUS;
    endcase
  end

endmodule

// File: rtl/mem_router_chk.sv
module mem_router_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cpu_addr,
  input logic        cpu_we,
  input logic [7:0]  cpu_wdata,
  input logic [7:0]  cpu_rdata,
  input logic        xram_en,
  input logic [1:0]  vid_mode,
  input logic        mbc_we,
  input logic        vram_we,
  input logic        xram_we,
  input logic        wram_we,
  input logic        io_we
);

  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  logic in_xram, in_oam, in_dead, in_hram;
  assign in_xram = (cpu_addr >= 16'hA000) && (cpu_addr < 16'hC000);
  assign in_oam  = (cpu_addr >= 16'hFE00) && (cpu_addr < 16'hFEA0);
  assign in_dead = (cpu_addr >= 16'hFEA0) && (cpu_addr < 16'hFF00);
  assign in_hram = (cpu_addr >= 16'hFF80) && (cpu_addr < 16'hFFFF);

  // R3: ROM-window writes only reach the bank controller
  p_rom_write_to_mbc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && !cpu_addr[15]) |-> (mbc_we && !vram_we && !xram_we && !wram_we && !io_we));

  p_one_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mbc_we, vram_we, xram_we, wram_we, io_we}));

  p_xram_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!xram_en && in_xram) |-> (cpu_rdata == 8'hFF && !xram_we));

  p_oam_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (vid_mode[1] && in_oam) |-> (cpu_rdata == 8'hFF));

  p_dead_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_dead |-> (cpu_rdata == 8'hFF && !mbc_we && !vram_we && !xram_we && !wram_we && !io_we));

  p_hram_readback_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !cpu_we && $past(cpu_we) && $past(in_hram) && cpu_addr == $past(cpu_addr))
      |-> (cpu_rdata == $past(cpu_wdata)));

endmodule

bind mem_router mem_router_chk u_chk (.*);

// File: tb/mem_router_test.sv
`timescale 1ns/1ps
module mem_router_test;

  localparam int BW = 7;
  localparam int RAW = BW + 14;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [15:0]    cpu_addr;
  logic           cpu_we;
  logic [7:0]     cpu_wdata;
  logic [7:0]     cpu_rdata;
  logic [BW-1:0]  rom_bank_sel;
  logic           xram_en;
  logic [1:0]     vid_mode;
  logic           mbc_we, vram_we, xram_we, wram_we, io_we;
  logic [RAW-1:0] rom_addr;
  logic [12:0]    vram_addr, xram_addr, wram_addr;
  logic [6:0]     io_addr;
  logic [7:0]     rom_rdata, vram_rdata, xram_rdata, wram_rdata, io_rdata;

  always #4 clk = ~clk;

  // external memory stubs: content is a fixed function of the address
  function automatic int f_rom(int a);  return (a & 255) ^ ((a >> 14) & 127); endfunction
  function automatic int f_vram(int a); return ((a & 255) ^ 8'h3C ^ ((a >> 8) & 31)) & 255; endfunction
  function automatic int f_xram(int a); return ((a & 255) ^ 8'h96 ^ ((a >> 8) & 31)) & 255; endfunction
  function automatic int f_wram(int a); return ((a & 255) + ((a >> 8) & 31)) & 255; endfunction
  function automatic int f_io(int a);   return (a & 127) ^ 8'hC3; endfunction

  assign rom_rdata  = 8'(f_rom(int'(rom_addr)));
  assign vram_rdata = 8'(f_vram(int'(vram_addr)));
  assign xram_rdata = 8'(f_xram(int'(xram_addr)));
  assign wram_rdata = 8'(f_wram(int'(wram_addr)));
  assign io_rdata   = 8'(f_io(int'(io_addr)));

  mem_router #(.ROM_BANK_W(BW)) uut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_we(cpu_we),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .rom_bank_sel(rom_bank_sel),
    .xram_en(xram_en), .vid_mode(vid_mode), .mbc_we(mbc_we),
    .rom_addr(rom_addr), .rom_rdata(rom_rdata),
    .vram_addr(vram_addr), .vram_we(vram_we), .vram_rdata(vram_rdata),
    .xram_addr(xram_addr), .xram_we(xram_we), .xram_rdata(xram_rdata),
    .wram_addr(wram_addr), .wram_we(wram_we), .wram_rdata(wram_rdata),
    .io_addr(io_addr), .io_we(io_we), .io_rdata(io_rdata)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  // model state for the internal stores
  int oam_m[int];
  int hram_m[int];
  int ie_m;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // strobe vector order: {mbc, vram, xram, wram, io}
  task automatic access(string tag, int a, bit we, int d);
    int exp_rd, exp_st, exp_ad, act_ad;
    bit has_ad;
    @(negedge clk);
    cpu_addr = 16'(a); cpu_we = we; cpu_wdata = 8'(d);
    #1;
    exp_st = 0; has_ad = 1; act_ad = 0;
    if (a < 'h4000) begin
      exp_ad = a; exp_rd = f_rom(exp_ad); act_ad = int'(rom_addr); if (we) exp_st = 16;
    end else if (a < 'h8000) begin
      exp_ad = int'(rom_bank_sel) * 16384 + (a % 16384);
      exp_rd = f_rom(exp_ad); act_ad = int'(rom_addr); if (we) exp_st = 16;
    end else if (a < 'hA000) begin
      exp_ad = a - 'h8000; exp_rd = f_vram(exp_ad); act_ad = int'(vram_addr); if (we) exp_st = 8;
    end else if (a < 'hC000) begin
      exp_ad = a - 'hA000; act_ad = int'(xram_addr);
      exp_rd = xram_en ? f_xram(exp_ad) : 255;
      if (we && xram_en) exp_st = 4;
    end else if (a < 'hFE00) begin
      if (a < 'hE000) exp_ad = a - 'hC000;
      else            exp_ad = a - 'hE000 + ((a >= 'hF000) ? 0 : 0);
      if (a >= 'hF000) exp_ad = 4096 + (a - 'hF000);
      exp_rd = f_wram(exp_ad); act_ad = int'(wram_addr); if (we) exp_st = 2;
    end else if (a < 'hFEA0) begin
      has_ad = 0;
      exp_rd = (vid_mode < 2) ? oam_m[a - 'hFE00] : 255;
    end else if (a < 'hFF00) begin
      has_ad = 0; exp_rd = 255;
    end else if (a < 'hFF80) begin
      exp_ad = a - 'hFF00; exp_rd = f_io(exp_ad); act_ad = int'(io_addr); if (we) exp_st = 1;
    end else if (a < 'hFFFF) begin
      has_ad = 0; exp_rd = hram_m[a - 'hFF80];
    end else begin
      has_ad = 0; exp_rd = ie_m;
    end
    chk({tag, " rdata"}, int'(cpu_rdata), exp_rd);
    chk({tag, " strobes"}, int'({mbc_we, vram_we, xram_we, wram_we, io_we}), exp_st);
    if (has_ad) chk({tag, " addr"}, act_ad, exp_ad);
    @(posedge clk);
    if (we) begin
      if (a >= 'hFE00 && a < 'hFEA0 && vid_mode < 2) oam_m[a - 'hFE00] = d;
      else if (a >= 'hFF80 && a < 'hFFFF) hram_m[a - 'hFF80] = d;
      else if (a == 'hFFFF) ie_m = d;
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cpu_addr = 16'h0000; cpu_we = 1'b0; cpu_wdata = 8'h00;
    rom_bank_sel = 7'd1; xram_en = 1'b0; vid_mode = 2'd0; ie_m = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    access("R12 reset", 'hFFFF, 0, 0);
    access("R1", 'h0000, 0, 0);
    access("R1", 'h1234, 0, 0);
    access("R1", 'h3FFF, 0, 0);
    rom_bank_sel = 7'd5;
    access("R2", 'h4000, 0, 0);
    access("R2", 'h7ABC, 0, 0);
    rom_bank_sel = 7'h7F;
    access("R2", 'h5555, 0, 0);
    access("R3", 'h2100, 1, 3);
    access("R3", 'h6000, 1, 1);
    access("R3", 'h0000, 1, 'h0A);
    access("R4", 'h8000, 0, 0);
    access("R4", 'h9FFF, 1, 'h42);
    access("R5 off", 'hA123, 0, 0);
    access("R5 off", 'hA123, 1, 9);
    xram_en = 1'b1;
    access("R5 on", 'hA123, 0, 0);
    access("R5 on", 'hBFFF, 1, 9);
    access("R6", 'hC010, 0, 0);
    access("R6", 'hE010, 1, 4);
    access("R6", 'hD010, 0, 0);
    access("R7", 'hF010, 0, 0);
    access("R7", 'hFDFF, 1, 6);
    vid_mode = 2'd0;
    access("R8 m0", 'hFE00, 1, 'h11);
    access("R8 m0", 'hFE9F, 1, 'h22);
    vid_mode = 2'd1;
    access("R8 m1", 'hFE00, 0, 0);
    vid_mode = 2'd2;
    access("R8 m2", 'hFE00, 1, 'h99);
    access("R8 m2", 'hFE00, 0, 0);
    vid_mode = 2'd3;
    access("R8 m3", 'hFE9F, 0, 0);
    vid_mode = 2'd0;
    access("R8 m0 kept", 'hFE00, 0, 0);
    access("R9", 'hFEA0, 1, 'h77);
    access("R9", 'hFEFF, 1, 'h78);
    access("R9", 'hFEA0, 0, 0);
    access("R9 oam kept", 'hFE9F, 0, 0);
    access("R9 oam kept", 'hFE00, 0, 0);
    access("R10", 'hFF00, 0, 0);
    access("R10", 'hFF7F, 0, 0);
    access("R10", 'hFF40, 1, 'h12);
    access("R11", 'hFF80, 1, 'hA5);
    access("R11", 'hFFFE, 1, 'h5A);
    access("R11", 'hFF80, 0, 0);
    access("R11", 'hFFFE, 0, 0);
    access("R12", 'hFFFF, 1, 'h1F);
    access("R12", 'hFFFF, 0, 0);
    access("R13", 'hFF90, 1, 1);
    access("R13", 'hFF90, 1, 2);
    access("R13", 'hFF90, 0, 0);
    access("R13", 'hFE10, 1, 'h33);
    access("R13", 'hFE10, 0, 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule